// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with One-Bit LRU

This block is a read-only cache holding 8 KB in 32-byte lines, addressed by a 34-bit byte address. The storage is split into sets of two ways. Each way keeps a valid flag, a tag and a full line. A request looks up the set named by the middle address bits and compares both stored tags against the request tag at the same time. When one way matches, the block answers with one 64-bit word from that way's line on the next clock.

On a miss the block drops its ready signal and asks the next memory level for the whole line. When the line arrives, it is written into a victim way together with its tag and valid flag. An empty way is always filled first, and way 0 is tried before way 1. Only when both ways are occupied does the per-set recency bit choose the way to evict. The stored access is then looked up again, and the answer it produces is a hit that carries a flag saying a refill was needed.

A parameter shrinks the set count to two. That gives a four-line cache, which is used to check a textbook replacement sequence.

Top module: `lru2_cache`

## Requirements
- R1: The address is split as tag = bits [33:12] (22 bits), set = bits [11:5] (7 bits, 128 sets) and line offset = bits [4:0]. Offset bits [4:3] select the 64-bit word of the line (word k is line bits [64k+63:64k]), and bits [2:0] do not affect the result.
- R2: After reset, reqReady is 1, respValid is 0, memReqValid is 0, every way of every set is empty, and every recency bit names way 1 as the next victim.
- R3: An accepted request (reqValid and reqReady) whose tag matches a valid way produces, on the next clock, respValid = 1, respMissed = 0, respWay = the matching way and respData = the addressed word. At most one way of a set ever matches.
- R4: An accepted request that misses lowers reqReady on the next clock and raises memReqValid with memReqAddr = request address bits [33:5]. Both hold steady until memRespValid is seen.
- R5: On a refill, if a way of the set is empty, the first empty way (way 0 before way 1) receives the line, whatever the recency bit says.
- R6: On a refill into a set whose two ways are both valid, the way named by the recency bit is replaced.
- R7: Every hit and every refill sets the set's recency bit to name the way that was not just used.
- R8: The clock that takes memRespValid writes the line, tag and valid flag. One clock later respValid = 1 with respMissed = 1, respWay = the filled way and respData = the addressed word of the new line.
- R9: While reqReady is 0, reqValid is ignored: the ignored request produces no response and does not fill a line.
- R10: With two sets (four lines), the line-address sequence 0, 4, 1, 2, 3, 1, 5 gives miss, miss, miss, miss, miss, hit, miss, with filled or hit ways 0, 1, 0, 0, 1, 0, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request strobe |
| reqAddr | input | 34 | Byte address of the request |
| reqReady | output | 1 | High when a request can be accepted |
| respValid | output | 1 | One-clock pulse marking a returned word |
| respData | output | 64 | Returned word |
| respWay | output | 1 | Way that supplied the word |
| respMissed | output | 1 | Set when the answer followed a refill |
| memReqValid | output | 1 | Line fetch request to the next level |
| memReqAddr | output | 29 | Line address of the fetch |
| memRespValid | input | 1 | Fetched line is present on memRespData |
| memRespData | input | 256 | Fetched line, word 0 in the low bits |

## Verification
The victim choice and the recency bit act in the same refill clock. The empty-way preference has to override a recency bit that points elsewhere, and the bit must be rewritten to name the other way in that same clock. Reset leaves every recency bit pointing at way 1, so the very first miss to a set pits an empty way 0 against that pointer. The bench then judges the outcome through respWay on the replayed answer and through which line survives the following evictions. A request raised during a refill checks that lookup and refill never share the set state.

// File: rtl/lru2_cache_pkg.sv
package lru2_cache_pkg;
  typedef struct packed {
    logic captureReq;
    logic useSaved;
    logic fillWrite;
    logic respond;
    logic markMiss;
  } cacheStrobes_t;
endpackage

// File: rtl/lru2_cache_dpath.sv
module lru2_cache_dpath
  import lru2_cache_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter int SET_W    = 7,
  parameter int OFFSET_W = 5,
  parameter int WORD_W   = 64,
  parameter int BLOCK_W  = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cacheStrobes_t                ctrl,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [BLOCK_W-1:0]           memRespData,
  output logic                         hit,
  output logic [1:0]                   wayHit,
  output logic                         respValid,
  output logic [WORD_W-1:0]            respData,
  output logic                         respWay,
  output logic                         respMissed,
  output logic [ADDR_W-OFFSET_W-1:0]   memReqAddr
);
  localparam int TAG_W  = ADDR_W - SET_W - OFFSET_W;
  localparam int SETS   = 1 << SET_W;
  localparam int WAYS   = 2;
  localparam int WORDS  = BLOCK_W / WORD_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BYTE_W = OFFSET_W - WSEL_W;

  logic [ADDR_W-1:0]  savedAddr;
  logic [ADDR_W-1:0]  lookAddr;
  logic [SET_W-1:0]   lookSet;
  logic [TAG_W-1:0]   lookTag;
  logic [WSEL_W-1:0]  lookWord;
  logic [WAYS-1:0]    validSel;
  logic [BLOCK_W-1:0] wayBlock [WAYS];
  logic [BLOCK_W-1:0] selBlock;
  logic               victimWay;
  logic               hitWay;
  logic [SETS-1:0]    lruQ;

  always_ff @(posedge clk) begin
    if (ctrl.captureReq) savedAddr <= reqAddr;
  end

  assign lookAddr   = ctrl.useSaved ? savedAddr : reqAddr;
  assign lookSet    = lookAddr[OFFSET_W +: SET_W];
  assign lookTag    = lookAddr[ADDR_W-1 -: TAG_W];
  assign lookWord   = lookAddr[BYTE_W +: WSEL_W];
  assign memReqAddr = savedAddr[ADDR_W-1:OFFSET_W];

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    logic [SETS-1:0]    validQ;
    logic [TAG_W-1:0]   tagQ  [SETS];
    logic [BLOCK_W-1:0] dataQ [SETS];
    logic               wrHere;

    assign wrHere      = ctrl.fillWrite && (victimWay == 1'(w));
    assign validSel[w] = validQ[lookSet];
    assign wayHit[w]   = validQ[lookSet] && (tagQ[lookSet] == lookTag);
    assign wayBlock[w] = dataQ[lookSet];

    always_ff @(posedge clk) begin
      if (!rstN) validQ <= '0;
      else if (wrHere) validQ[lookSet] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        tagQ[lookSet]  <= lookTag;
        dataQ[lookSet] <= memRespData;
      end
    end
  end

  assign hit      = |wayHit;
  assign hitWay   = wayHit[1];
  assign selBlock = wayBlock[hitWay];

  always_comb begin
    if (!validSel[0])      victimWay = 1'b0;
    else if (!validSel[1]) victimWay = 1'b1;
    else                   victimWay = lruQ[lookSet];
  end

  always_ff @(posedge clk) begin
    if (!rstN) lruQ <= '1;
    else if (ctrl.fillWrite) lruQ[lookSet] <= ~victimWay;
    else if (ctrl.respond)   lruQ[lookSet] <= ~hitWay;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respData   <= '0;
      respWay    <= 1'b0;
      respMissed <= 1'b0;
    end else begin
      respValid <= ctrl.respond;
      if (ctrl.respond) begin
        respData   <= selBlock[lookWord*WORD_W +: WORD_W];
        respWay    <= hitWay;
        respMissed <= ctrl.markMiss;
      end
    end
  end
endmodule

// File: rtl/lru2_cache_ctrl.sv
module lru2_cache_ctrl
  import lru2_cache_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          hit,
  input  logic          memRespValid,
  output cacheStrobes_t ctrl,
  output logic          reqReady,
  output logic          memReqValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_REPLAY} ctrlState_t;
  ctrlState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_FILL);

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.captureReq = 1'b1;
          if (hit) ctrl.respond = 1'b1;
          else     stateD = ST_FILL;
        end
      end
      ST_FILL: begin
        ctrl.useSaved = 1'b1;
        if (memRespValid) begin
          ctrl.fillWrite = 1'b1;
          stateD = ST_REPLAY;
        end
      end
      ST_REPLAY: begin
        ctrl.useSaved = 1'b1;
        ctrl.respond  = 1'b1;
        ctrl.markMiss = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/lru2_cache.sv
module lru2_cache
  import lru2_cache_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter int SET_W    = 7,
  parameter int OFFSET_W = 5,
  parameter int WORD_W   = 64,
  parameter int BLOCK_W  = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [ADDR_W-1:0]          reqAddr,
  output logic                       reqReady,
  output logic                       respValid,
  output logic [WORD_W-1:0]          respData,
  output logic                       respWay,
  output logic                       respMissed,
  output logic                       memReqValid,
  output logic [ADDR_W-OFFSET_W-1:0] memReqAddr,
  input  logic                       memRespValid,
  input  logic [BLOCK_W-1:0]         memRespData
);
  cacheStrobes_t strobes;
  logic          hit;
  logic [1:0]    wayHit;

  lru2_cache_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .memRespValid(memRespValid), .ctrl(strobes),
    .reqReady(reqReady), .memReqValid(memReqValid)
  );

  lru2_cache_dpath #(
    .ADDR_W(ADDR_W), .SET_W(SET_W), .OFFSET_W(OFFSET_W),
    .WORD_W(WORD_W), .BLOCK_W(BLOCK_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .ctrl(strobes), .reqAddr(reqAddr),
    .memRespData(memRespData), .hit(hit), .wayHit(wayHit),
    .respValid(respValid), .respData(respData), .respWay(respWay),
    .respMissed(respMissed), .memReqAddr(memReqAddr)
  );
endmodule

// File: rtl/lru2_cache_chk.sv
module lru2_cache_chk #(
  parameter int BLK_W = 29
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             hit,
  input logic [1:0]       wayHit,
  input logic             respValid,
  input logic             respMissed,
  input logic             memReqValid,
  input logic             memRespValid,
  input logic [BLK_W-1:0] memReqAddr
);
  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wayHit) <= 1); // R3
  AST_HIT_ANSWERS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && hit) |=> (respValid && !respMissed)); // R3
  AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !hit) |=> (memReqValid && !reqReady)); // R4
  AST_FETCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRespValid) |=> (memReqValid && $stable(memReqAddr))); // R4
  AST_REPLAY_ANSWERS: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRespValid) |=> ##1 (respValid && respMissed)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady); // R9
endmodule

bind lru2_cache lru2_cache_chk #(.BLK_W(ADDR_W - OFFSET_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .hit(hit), .wayHit(wayHit), .respValid(respValid), .respMissed(respMissed),
  .memReqValid(memReqValid), .memRespValid(memRespValid), .memReqAddr(memReqAddr)
);

// File: tb/test_lru2_cache.sv
module test_lru2_cache;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // main instance
  logic         reqValid = 1'b0;
  logic [33:0]  reqAddr = '0;
  logic         reqReady, respValid, respWay, respMissed, memReqValid;
  logic [63:0]  respData;
  logic [28:0]  memReqAddr;
  logic         memRespValid = 1'b0;
  logic [255:0] memRespData = '0;

  // four-line instance
  logic         sReqValid = 1'b0;
  logic [33:0]  sReqAddr = '0;
  logic         sReqReady, sRespValid, sRespWay, sRespMissed, sMemReqValid;
  logic [63:0]  sRespData;
  logic [28:0]  sMemReqAddr;
  logic         sMemRespValid = 1'b0;
  logic [255:0] sMemRespData = '0;

  lru2_cache i_lru2_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .respValid(respValid), .respData(respData),
    .respWay(respWay), .respMissed(respMissed), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRespValid(memRespValid), .memRespData(memRespData)
  );

  lru2_cache #(.SET_W(1)) i_small (
    .clk(clk), .rstN(rstN), .reqValid(sReqValid), .reqAddr(sReqAddr),
    .reqReady(sReqReady), .respValid(sRespValid), .respData(sRespData),
    .respWay(sRespWay), .respMissed(sRespMissed), .memReqValid(sMemReqValid),
    .memReqAddr(sMemReqAddr), .memRespValid(sMemRespValid), .memRespData(sMemRespData)
  );

  function automatic logic [63:0] lineWord(input logic [28:0] line, input logic [1:0] k);
    return {3'b000, line, 30'h2AAAAAAA, k};
  endfunction

  function automatic logic [255:0] lineData(input logic [28:0] line);
    logic [255:0] d;
    for (int k = 0; k < 4; k++) d[k*64 +: 64] = lineWord(line, 2'(k));
    return d;
  endfunction

  // next-level memory models: answer two negedges after the request appears
  int lat = 0;
  always @(negedge clk) begin
    if (memReqValid && !memRespValid) begin
      if (lat == 2) begin
        memRespValid <= 1'b1;
        memRespData  <= lineData(memReqAddr);
        lat <= 0;
      end else lat <= lat + 1;
    end else memRespValid <= 1'b0;
  end

  int sLat = 0;
  always @(negedge clk) begin
    if (sMemReqValid && !sMemRespValid) begin
      if (sLat == 2) begin
        sMemRespValid <= 1'b1;
        sMemRespData  <= lineData(sMemReqAddr);
        sLat <= 0;
      end else sLat <= sLat + 1;
    end else sMemRespValid <= 1'b0;
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic doAccess(input logic [33:0] addr, input logic expMiss,
                          input logic expWay, input string what);
    int n;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = addr;
    @(posedge clk); #1;
    reqValid = 1'b0;
    if (expMiss) begin
      chk({what, " R4 memReqValid"}, 64'(memReqValid), 64'd1);
      chk({what, " R4 memReqAddr"}, 64'(memReqAddr), 64'(addr[33:5]));
      chk({what, " R9 reqReady low"}, 64'(reqReady), 64'd0);
    end
    n = 0;
    while (!respValid && n < 40) begin
      @(posedge clk); #1;
      n++;
    end
    chk({what, " R3 R8 respValid"}, 64'(respValid), 64'd1);
    chk({what, " R8 respMissed"}, 64'(respMissed), 64'(expMiss));
    chk({what, " R5 R6 R7 respWay"}, 64'(respWay), 64'(expWay));
    chk({what, " R1 respData"}, respData, lineWord(addr[33:5], addr[4:3]));
  endtask

  task automatic doSmall(input logic [28:0] line, input logic expMiss,
                         input logic expWay);
    int n;
    @(negedge clk);
    sReqValid = 1'b1;
    sReqAddr  = {line, 5'b0};
    @(posedge clk); #1;
    sReqValid = 1'b0;
    n = 0;
    while (!sRespValid && n < 40) begin
      @(posedge clk); #1;
      n++;
    end
    chk($sformatf("R10 line %0d respMissed", line), 64'(sRespMissed), 64'(expMiss));
    chk($sformatf("R10 line %0d respWay", line), 64'(sRespWay), 64'(expWay));
    chk($sformatf("R10 line %0d respData", line), sRespData, lineWord(line, 2'd0));
  endtask

  // main vectors: {tag, set, word, expMiss, expWay}
  localparam int NMAIN = 9;
  localparam logic [32:0] MAIN_VEC [NMAIN] = '{
    {22'd1, 7'd5, 2'd2, 1'b1, 1'b0},  // A: empty way 0 wins over pointer at way 1 (R5, R2)
    {22'd1, 7'd5, 2'd1, 1'b0, 1'b0},  // A hit (R3, R1)
    {22'd2, 7'd5, 2'd0, 1'b1, 1'b1},  // B: way 1 still empty (R5)
    {22'd1, 7'd5, 2'd3, 1'b0, 1'b0},  // A hit points recency at way 1 (R7)
    {22'd3, 7'd5, 2'd0, 1'b1, 1'b1},  // C evicts B (R6)
    {22'd2, 7'd5, 2'd2, 1'b1, 1'b0},  // B back, evicts A (R6, R7)
    {22'd3, 7'd5, 2'd1, 1'b0, 1'b1},  // C hit (R3)
    {22'd1, 7'd5, 2'd0, 1'b1, 1'b0},  // A evicts B (R7)
    {22'd1, 7'd6, 2'd0, 1'b1, 1'b0}   // other set untouched (R5)
  };

  // four-line vectors: {line, expMiss, expWay}
  localparam int NSMALL = 7;
  localparam logic [9:0] SMALL_VEC [NSMALL] = '{
    {8'd0, 1'b1, 1'b0}, {8'd4, 1'b1, 1'b1}, {8'd1, 1'b1, 1'b0},
    {8'd2, 1'b1, 1'b0}, {8'd3, 1'b1, 1'b1}, {8'd1, 1'b0, 1'b0},
    {8'd5, 1'b1, 1'b1}
  };

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state
    chk("R2 reqReady", 64'(reqReady), 64'd1);
    chk("R2 respValid", 64'(respValid), 64'd0);
    chk("R2 memReqValid", 64'(memReqValid), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NMAIN; i++) begin
      logic [33:0] a;
      a = {MAIN_VEC[i][32:11], MAIN_VEC[i][10:4], MAIN_VEC[i][3:2], 3'b101};
      doAccess(a, MAIN_VEC[i][1], MAIN_VEC[i][0], $sformatf("vec%0d", i));
    end

    // R9: request raised during a refill is dropped
    begin
      logic [33:0] aE, aF;
      int seen;
      aE = {22'd4, 7'd9, 2'd1, 3'b000};
      aF = {22'd5, 7'd9, 2'd2, 3'b000};
      @(negedge clk);
      reqValid = 1'b1; reqAddr = aE;
      @(negedge clk);
      reqAddr = aF;
      @(negedge clk);
      reqValid = 1'b0;
      seen = 0;
      for (int c = 0; c < 12; c++) begin
        @(posedge clk); #1;
        if (respValid) begin
          seen++;
          chk("R9 answer belongs to first request", respData, lineWord(aE[33:5], 2'd1));
        end
      end
      chk("R9 single response", 64'(seen), 64'd1);
      doAccess(aF, 1'b1, 1'b1, "R9 dropped request was not filled");
    end

    for (int i = 0; i < NSMALL; i++)
      doSmall(29'(SMALL_VEC[i][9:2]), SMALL_VEC[i][1], SMALL_VEC[i][0]);

    repeat (2) @(posedge clk);
    finish();
  end
endmodule